// File: doc/BRIEF.md
# Two-Bit Interrupt Priority Resolver

This block picks which interrupt a small microcontroller core should take next. The core has seven priority groups: two external pins, two basic timers, the serial group, the third timer and the analog comparator. Each group gets a level from 0 to 3, built from one bit in a low priority register and one bit in a high priority register. Some groups are fed by more than one hardware flag, and those flags share the group's priority bit and enable bit. The resolver ORs the flags of each group and masks them with the global and per-group enables. It then returns the winning group, which is the one with the highest level, with ties going to the lowest group number. The choice and its level are computed combinationally.

A four-bit in-service mask records which levels are being serviced. A request is raised only when the winner's level is strictly above the highest level in that mask. When the core accepts the request, it pulses `take`, which marks the winner's level as in service. When a handler finishes, `ret` clears the highest marked level. A build-time parameter models a part without the high priority register, in which case that register reads as zero.

Top module: `irq_rank_resolver`

## Requirements
- R1: A group's level equals its `prio_lo` bit plus twice its `prio_hi` bit. Bit g of each priority register belongs to group g, in this order: 0 external pin 0, 1 timer 0, 2 external pin 1, 3 timer 1, 4 serial, 5 timer 2, 6 comparator.
- R2: Flag bits map to groups as follows. `flags[0]`→0, `[1]`→1, `[2]`→2, `[3]`→3, `[4]` receive, `[5]` transmit and `[6]` SPI all go to group 4, `[7]` timer-2 external and `[8]` timer-2 overflow go to group 5, and `[9]`→6. A group is pending when any of its flags is set.
- R3: `en[7]` is the global enable, and `en[g]` enables group g for g = 0..6. A disabled group never wins, and with `en[7]` low `req` is 0.
- R4: `vec` and `lvl` give the enabled pending group with the highest level. Among equal levels the lowest group number wins. With nothing pending, `vec` and `lvl` read 0.
- R5: `req` is 1 only when a group is eligible and its level is strictly above the highest set bit of `active`. When `active` is 0, any eligible group raises `req`.
- R6: A clock edge with `take` and `req` high sets `active[lvl]`. `take` while `req` is low leaves `active` unchanged.
- R7: A clock edge with `ret` high clears the highest set bit of `active`. On an empty mask it has no effect. When `ret` and an accepted `take` share an edge, the clear happens first and the set second.
- R8: With `HI_PRESENT` = 0, `prio_hi` is treated as all zeros.
- R9: After reset, `active` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prio_lo | input | 7 | Low priority bit per group |
| prio_hi | input | 7 | High priority bit per group |
| en | input | 8 | Bit 7 global enable, bits 6..0 group enables |
| flags | input | 10 | Hardware interrupt flags |
| take | input | 1 | Core accepts the current request |
| ret | input | 1 | Return from the current handler |
| req | output | 1 | Preemption request |
| vec | output | 3 | Winning group number |
| lvl | output | 2 | Winning level |
| active | output | 4 | In-service level mask |

## Verification
The assertions check on every cycle that a request never appears at or below an in-service level and never appears with the global enable off. They also check that an accepted take marks its level, that a return removes exactly one level, and that the mask holds steady when neither event occurs. Whether the right group wins, including the tie order, the flag-to-group mapping and the effect of a missing high register, can only be shown by the bench's sweeps over priority, flag and enable patterns. The bench compares those results against levels computed arithmetically. The ordering of a return and a take on the same edge is shown by a scripted sequence.

// File: rtl/irq_rank_resolver.sv
module irq_rank_resolver #(
  parameter int HI_PRESENT = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [6:0] prio_lo,
  input  logic [6:0] prio_hi,
  input  logic [7:0] en,
  input  logic [9:0] flags,
  input  logic       take,
  input  logic       ret,
  output logic       req,
  output logic [2:0] vec,
  output logic [1:0] lvl,
  output logic [3:0] active
);
  localparam int GROUPS = 7;
  localparam int LEVELS = 4;

  logic [GROUPS-1:0] grp_raw, grp_pend, hi_eff;
  logic              found, top_valid;
  logic [2:0]        best_idx;
  logic [1:0]        best_lvl, top_lvl, g_lvl;
  logic [LEVELS-1:0] mask_next;

  assign grp_raw  = {flags[9], flags[8] | flags[7], flags[6] | flags[5] | flags[4],
                     flags[3], flags[2], flags[1], flags[0]};
  assign grp_pend = grp_raw & en[GROUPS-1:0] & {GROUPS{en[7]}};
  assign hi_eff   = (HI_PRESENT != 0) ? prio_hi : '0;

  always_comb begin
    found    = 1'b0;
    best_idx = '0;
    best_lvl = '0;
    g_lvl    = '0;
    for (int g = 0; g < GROUPS; g++) begin
      g_lvl = {hi_eff[g], prio_lo[g]};
      if (grp_pend[g] && (!found || g_lvl > best_lvl)) begin
        found    = 1'b1;
        best_idx = 3'(g);
        best_lvl = g_lvl;
      end
    end
  end

  always_comb begin
    top_valid = |active;
    top_lvl   = '0;
    for (int l = 0; l < LEVELS; l++)
      if (active[l]) top_lvl = 2'(l);
  end

  assign req = found && (!top_valid || best_lvl > top_lvl);
  assign vec = best_idx;
  assign lvl = best_lvl;

  always_comb begin
    mask_next = active;
    if (ret && top_valid) mask_next[top_lvl] = 1'b0;
    if (take && req)      mask_next[best_lvl] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) active <= '0;
    else        active <= mask_next;
endmodule

module irq_rank_resolver_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] en,
  input logic       take,
  input logic       ret,
  input logic       req,
  input logic [2:0] vec,
  input logic [1:0] lvl,
  input logic [3:0] active
);
  // R5
  above_stack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> ((active >> lvl) == 4'd0));
  // R3
  global_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en[7] |-> !req);
  // R6
  take_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && req) |=> active[$past(lvl)]);
  // R6
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(take && req) && !ret) |=> $stable(active));
  // R7
  ret_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && !take && active != 4'd0) |=> ($countones(active) + 1 == $countones($past(active))));
  // R4
  vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec < 3'd7);
endmodule

bind irq_rank_resolver irq_rank_resolver_chk chk_i (.*);

// File: tb/irq_rank_resolver_test.sv
`timescale 1ns/1ps
module irq_rank_resolver_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] prio_lo = '0, prio_hi = '0;
  logic [7:0] en = '0;
  logic [9:0] flags = '0;
  logic       take = 1'b0, ret = 1'b0;
  logic       req, req_n;
  logic [2:0] vec, vec_n;
  logic [1:0] lvl, lvl_n;
  logic [3:0] active, active_n;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_rank_resolver #(.HI_PRESENT(1)) uut (.clk, .rst_n, .prio_lo, .prio_hi, .en, .flags,
    .take, .ret, .req, .vec, .lvl, .active);
  irq_rank_resolver #(.HI_PRESENT(0)) uut_nohi (.clk, .rst_n, .prio_lo, .prio_hi, .en, .flags,
    .take(1'b0), .ret(1'b0), .req(req_n), .vec(vec_n), .lvl(lvl_n), .active(active_n));

  function automatic logic [5:0] model(logic [6:0] lo, logic [6:0] hi, logic [7:0] e,
                                       logic [9:0] f, logic [3:0] m, bit hipres);
    logic [6:0] pend;
    int best = -1, bidx = 0, top = -1, lv;
    pend = {f[9], f[8] | f[7], f[6] | f[5] | f[4], f[3], f[2], f[1], f[0]};
    for (int g = 0; g < 7; g++) begin
      lv = int'(lo[g]) + (hipres ? 2 * int'(hi[g]) : 0);
      if (pend[g] && e[g] && e[7] && lv > best) begin
        best = lv;
        bidx = g;
      end
    end
    for (int l = 0; l < 4; l++) if (m[l]) top = l;
    if (best < 0) return 6'd0;
    return {(best > top) ? 1'b1 : 1'b0, 3'(bidx), 2'(best)};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse(logic t, logic r);
    @(negedge clk);
    take = t;
    ret  = r;
    @(negedge clk);
    take = 1'b0;
    ret  = 1'b0;
    #1;
  endtask

  task automatic drive(logic [6:0] lo, logic [6:0] hi, logic [7:0] e, logic [9:0] f);
    @(negedge clk);
    prio_lo = lo;
    prio_hi = hi;
    en      = e;
    flags   = f;
    #1;
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R9 reset state
    chk("R9 active", active, 0);
    chk("R9 outputs idle", {req, vec, lvl}, 0);

    // R1 R4 R8: every priority pair, all sources pending
    for (int lo = 0; lo < 128; lo++)
      for (int hi = 0; hi < 128; hi++) begin
        prio_lo = 7'(lo);
        prio_hi = 7'(hi);
        en = 8'hFF;
        flags = 10'h3FF;
        #4;
        chk("R1/R4 winner", {req, vec, lvl}, model(7'(lo), 7'(hi), 8'hFF, 10'h3FF, 4'd0, 1'b1));
        chk("R8 no high reg", {req_n, vec_n, lvl_n}, model(7'(lo), 7'(hi), 8'hFF, 10'h3FF, 4'd0, 1'b0));
      end

    // R2 flag to group mapping
    for (int f = 0; f < 1024; f++) begin
      prio_lo = 7'h55;
      prio_hi = 7'h33;
      en = 8'hFF;
      flags = 10'(f);
      #4;
      chk("R2 mapping", {req, vec, lvl}, model(7'h55, 7'h33, 8'hFF, 10'(f), 4'd0, 1'b1));
    end

    // R3 enables
    for (int e = 0; e < 256; e++) begin
      prio_lo = 7'h2A;
      prio_hi = 7'h4C;
      en = 8'(e);
      flags = 10'h3FF;
      #4;
      chk("R3 enables", {req, vec, lvl}, model(7'h2A, 7'h4C, 8'(e), 10'h3FF, 4'd0, 1'b1));
    end

    // R5 R6 R7 in-service sequence
    drive(7'h01, 7'h00, 8'hFF, 10'h001);
    chk("R5 empty mask request", {req, vec, lvl}, {1'b1, 3'd0, 2'd1});
    pulse(1'b1, 1'b0);
    chk("R6 take marks level 1", active, 4'b0010);
    chk("R5 equal level blocked", req, 0);
    drive(7'h03, 7'h02, 8'hFF, 10'h003);
    chk("R5 higher level preempts", {req, vec, lvl}, {1'b1, 3'd1, 2'd3});
    pulse(1'b1, 1'b0);
    chk("R6 take marks level 3", active, 4'b1010);
    chk("R5 blocked at top", req, 0);
    pulse(1'b1, 1'b0);
    chk("R6 take without req ignored", active, 4'b1010);
    pulse(1'b0, 1'b1);
    chk("R7 ret clears highest", active, 4'b0010);
    chk("R5 request returns", {req, vec, lvl}, {1'b1, 3'd1, 2'd3});
    pulse(1'b1, 1'b1);
    chk("R7 ret then take", active, 4'b1000);
    pulse(1'b0, 1'b1);
    chk("R7 ret to empty", active, 4'b0000);
    pulse(1'b0, 1'b1);
    chk("R7 ret on empty", active, 4'b0000);
    drive(7'h01, 7'h00, 8'h7F, 10'h001);
    chk("R3 global off no req", req, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule